// File: doc/BRIEF.md
# LPC Host I/O Cycle Sequencer

This block sits on the host side of a 4-bit multiplexed LPC bus. It turns processor I/O reads and writes into LPC I/O cycles. Requests arrive on a valid/ready port and carry a 16-bit I/O address, a width code, write data and a direction flag. A request goes onto the bus only if its start address falls inside one of two programmable decode windows. A request that misses both windows is answered at once and causes no bus activity.

Every bus cycle moves one byte. A 2-byte or 4-byte request is therefore issued as a run of byte cycles at rising addresses, and the read bytes are packed into one response word. The block drives the frame strobe and the LAD nibble. It also drives a separate output-enable, which the pad ring uses to release the lines. It decodes the peripheral's SYNC nibble, including wait, error and no-response cases. A read that gets no SYNC in time is aborted and returns FFh for that byte. A suspend input parks the bus whenever the sequencer is idle.

Top module: `lpc_io_seq`

## Requirements
- R1: `req_ready_o` is high exactly when no access is in progress and `suspend_i` is low. A request presented while `req_ready_o` is low is ignored: the bus stays unchanged and no response follows.
- R2: A request whose address misses every enabled window starts no bus cycle. One cycle after it is accepted, the block returns a response with `rsp_fwd_o`=0, `rsp_err_o`=0 and `rsp_rdata_o`=FFFF_FFFFh. An accepted hit starts its first START clock in the very next cycle.
- R3: Each byte cycle drives the following nibbles, in order:
  - START: LAD=0000 with the frame strobe low.
  - One direction nibble: 0000 for a read, 0010 for a write.
  - Four address nibbles, most significant first.
  - For a write only: the data low nibble, then the high nibble.
  - One clock of 1111, after which the host releases LAD (`lad_oe_o`=0).
- R4: The width code sets the number of byte cycles: 0 gives 1, 1 gives 2, and 2 or 3 gives 4. Byte cycle i uses address base+i and write byte `req_wdata_i[8i+7:8i]`. Each byte cycle's START follows the previous cycle's last clock with no gap.
- R5: After the released clock, LAD is sampled every clock:
  - 0000 (ready) ends the wait.
  - 0101 or 0110 (wait) extends it for as long as it is held.
  - 1010 (error) ends the wait like ready and sets `rsp_err_o` in the response.
  - A read then takes the data low nibble and then the high nibble.
  - Two released clocks close the byte cycle.
- R6: If four consecutive sampled clocks carry no ready, wait or error code, the byte cycle is aborted. The frame strobe is held low with LAD=1111 driven for four clocks, and a read byte becomes FFh.
- R7: Read bytes are packed little-endian, with byte i in `rsp_rdata_o[8i+7:8i]` and the unused upper bytes set to zero. A write returns zero data. A single one-cycle `rsp_valid_o` pulse with `rsp_fwd_o`=1 comes one cycle after the last byte cycle's final clock.
- R8: While the sequencer is idle and `suspend_i` is high, the frame strobe is low and `lad_oe_o` is 0. An access already in progress when suspend rises runs to completion first.
- R9: There are two decode windows. A pulse on `cfg_we_i` loads window `cfg_idx_i` with a base, a size of 2^`cfg_log2_i` bytes and an enable. An enabled window matches when the start address agrees with the base above the size bits. Both windows are disabled after reset.
- R10: After reset the frame strobe is high, `lad_oe_o` is 0, `rsp_valid_o` is 0 and `req_ready_o` is high while `suspend_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| suspend_i | input | 1 | Park request |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_addr_i | input | 16 | I/O start address |
| req_size_i | input | 2 | Width code: 0 byte, 1 two bytes, 2/3 four bytes |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_wdata_i | input | 32 | Write data, byte 0 at bits 7:0 |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_rdata_o | output | 32 | Assembled read data |
| rsp_err_o | output | 1 | A byte cycle returned the error SYNC |
| rsp_fwd_o | output | 1 | Access went to the bus (window hit) |
| cfg_we_i | input | 1 | Window load strobe |
| cfg_idx_i | input | 1 | Window index |
| cfg_base_i | input | 16 | Window base address |
| cfg_log2_i | input | 5 | Window size as a power of two |
| cfg_en_i | input | 1 | Window enable |
| lframe_n_o | output | 1 | Frame strobe, active low |
| lad_o | output | 4 | LAD nibble driven by the host |
| lad_oe_o | output | 1 | LAD output enable |
| lad_i | input | 4 | LAD nibble seen on the bus |

## Verification
The hardest state to reach from the ports is a four-byte read whose second byte times out and whose third byte ends in error. In that case an abort must fall in the middle of a run, the FFh byte must land in the right lane, and the error flag must survive to the single response. The bench acts as the peripheral and scripts a SYNC pattern for each byte: a number of wait clocks, then ready, error or silence. Its cycle model expects the matching nibble trace on every clock. Suspend is raised a few clocks into a live access, so the completion rule and the later park are both observed on the same run.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

  typedef enum logic [3:0] {
    F_IDLE, F_START, F_CT, F_ADDR, F_WDAT, F_TAR0, F_TAR1,
    F_SYNC, F_RDAT, F_TE0, F_TE1, F_ABORT
  } frm_state_e;

  typedef enum logic {T_IDLE, T_BUSY} seq_state_e;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] NIB_IO_RD  = 4'h0;
  localparam logic [3:0] NIB_IO_WR  = 4'h2;
  localparam logic [3:0] NIB_PARK   = 4'hF;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_SHORT = 4'h5;
  localparam logic [3:0] SYNC_LONG  = 4'h6;
  localparam logic [3:0] SYNC_ERROR = 4'hA;

  // width code -> index of last byte cycle
  function automatic logic [1:0] last_byte(input logic [1:0] size);
    case (size)
      2'd0:    last_byte = 2'd0;
      2'd1:    last_byte = 2'd1;
      default: last_byte = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/lpc_io_decode.sv
module lpc_io_decode #(
  parameter int AW = 16,
  parameter int NW = 2,
  localparam int LW = $clog2(AW + 1),
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [LW-1:0] cfg_log2_i,
  input  logic          cfg_en_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);

  logic [NW-1:0] win_hit;

  for (genvar w = 0; w < NW; w++) begin : g_win
    logic [AW-1:0] base_q;
    logic [LW-1:0] lg_q;
    logic          en_q;
    logic [AW-1:0] keep;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        lg_q   <= '0;
        en_q   <= 1'b0;
      end else if (cfg_we_i && cfg_idx_i == IW'(w)) begin
        base_q <= cfg_base_i;
        lg_q   <= cfg_log2_i;
        en_q   <= cfg_en_i;
      end
    end

    assign keep       = {AW{1'b1}} << lg_q;
    assign win_hit[w] = en_q && ((addr_i & keep) == (base_q & keep));
  end

  assign hit_o = |win_hit;

endmodule

// File: rtl/lpc_io_frame.sv
module lpc_io_frame
  import lpc_io_pkg::*;
#(
  parameter int AW         = 16,
  parameter int SYNC_TO    = 4,
  parameter int ABORT_CLKS = 4,
  localparam int NIBS = AW / 4,
  localparam int MAXC = (SYNC_TO > ABORT_CLKS) ? ((SYNC_TO > NIBS) ? SYNC_TO : NIBS)
                                               : ((ABORT_CLKS > NIBS) ? ABORT_CLKS : NIBS),
  localparam int CW = $clog2(MAXC) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          park_i,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic [3:0]    lad_i,
  output logic          done_o,
  output logic          idle_o,
  output logic [7:0]    byte_o,
  output logic          err_o,
  output logic          lframe_n_o,
  output logic [3:0]    lad_o,
  output logic          lad_oe_o
);

  frm_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdata_q;
  logic          write_q;
  logic [7:0]    byte_q, byte_d;
  logic          err_q, err_d;
  logic          done;
  logic          load;

  assign load = start_i && (state_q == F_IDLE || done);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    byte_d  = byte_q;
    err_d   = err_q;
    done    = 1'b0;
    case (state_q)
      F_IDLE:  if (start_i) state_d = F_START;
      F_START: state_d = F_CT;
      F_CT: begin
        state_d = F_ADDR;
        cnt_d   = '0;
      end
      F_ADDR: begin
        if (cnt_q == CW'(NIBS - 1)) begin
          cnt_d   = '0;
          state_d = write_q ? F_WDAT : F_TAR0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      F_WDAT: begin
        if (cnt_q == CW'(1)) state_d = F_TAR0;
        else                 cnt_d   = cnt_q + CW'(1);
      end
      F_TAR0: state_d = F_TAR1;
      F_TAR1: begin
        state_d = F_SYNC;
        cnt_d   = '0;
      end
      F_SYNC: begin
        case (lad_i)
          SYNC_READY, SYNC_ERROR: begin
            err_d   = err_q | (lad_i == SYNC_ERROR);
            cnt_d   = '0;
            state_d = write_q ? F_TE0 : F_RDAT;
          end
          SYNC_SHORT, SYNC_LONG: cnt_d = '0;
          default: begin
            if (cnt_q == CW'(SYNC_TO - 1)) begin
              state_d = F_ABORT;
              cnt_d   = '0;
              byte_d  = 8'hFF;
            end else begin
              cnt_d = cnt_q + CW'(1);
            end
          end
        endcase
      end
      F_RDAT: begin
        if (cnt_q == '0) begin
          byte_d[3:0] = lad_i;
          cnt_d       = CW'(1);
        end else begin
          byte_d[7:4] = lad_i;
          state_d     = F_TE0;
        end
      end
      F_TE0: state_d = F_TE1;
      F_TE1: done = 1'b1;
      F_ABORT: begin
        if (cnt_q == CW'(ABORT_CLKS - 1)) done = 1'b1;
        else                               cnt_d = cnt_q + CW'(1);
      end
      default: state_d = F_IDLE;
    endcase
    if (done) begin
      state_d = start_i ? F_START : F_IDLE;
      cnt_d   = '0;
    end
    if (load) begin
      byte_d = '0;
      err_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      err_q   <= err_d;
      if (load) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        write_q <= write_i;
      end
    end
  end

  always_comb begin
    lframe_n_o = 1'b1;
    lad_oe_o   = 1'b0;
    lad_o      = NIB_PARK;
    case (state_q)
      F_IDLE:  lframe_n_o = !park_i;
      F_START: begin
        lframe_n_o = 1'b0;
        lad_oe_o   = 1'b1;
        lad_o      = NIB_START;
      end
      F_CT: begin
        lad_oe_o = 1'b1;
        lad_o    = write_q ? NIB_IO_WR : NIB_IO_RD;
      end
      F_ADDR: begin
        lad_oe_o = 1'b1;
        lad_o    = addr_q[(NIBS - 1 - int'(cnt_q)) * 4 +: 4];
      end
      F_WDAT: begin
        lad_oe_o = 1'b1;
        lad_o    = cnt_q[0] ? wdata_q[7:4] : wdata_q[3:0];
      end
      F_TAR0:  lad_oe_o = 1'b1;
      F_ABORT: begin
        lframe_n_o = 1'b0;
        lad_oe_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign done_o = done;
  assign idle_o = (state_q == F_IDLE);
  assign byte_o = byte_q;
  assign err_o  = err_q;

endmodule

// File: rtl/lpc_io_seq.sv
module lpc_io_seq
  import lpc_io_pkg::*;
#(
  parameter int AW         = 16,
  parameter int NW         = 2,
  parameter int SYNC_TO    = 4,
  parameter int ABORT_CLKS = 4,
  localparam int LW = $clog2(AW + 1),
  localparam int IW = (NW > 1) ? $clog2(NW) : 1,
  localparam int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          suspend_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_write_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          rsp_err_o,
  output logic          rsp_fwd_o,
  input  logic          cfg_we_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic [AW-1:0] cfg_base_i,
  input  logic [LW-1:0] cfg_log2_i,
  input  logic          cfg_en_i,
  output logic          lframe_n_o,
  output logic [3:0]    lad_o,
  output logic          lad_oe_o,
  input  logic [3:0]    lad_i
);

  seq_state_e    st_q;
  logic [AW-1:0] base_q;
  logic [1:0]    last_q, idx_q, idx_nx;
  logic          write_q;
  logic [DW-1:0] wdata_q, acc_q, acc_nx;
  logic          err_q;
  logic          rsp_valid_q, rsp_err_q, rsp_fwd_q;
  logic [DW-1:0] rsp_rdata_q;

  logic          dec_hit, accept, more;
  logic          frm_start, frm_done, frm_idle, frm_err, frm_write;
  logic [7:0]    frm_byte, frm_wdata;
  logic [AW-1:0] frm_addr;

  lpc_io_decode #(.AW(AW), .NW(NW)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_base_i (cfg_base_i),
    .cfg_log2_i (cfg_log2_i),
    .cfg_en_i   (cfg_en_i),
    .addr_i     (req_addr_i),
    .hit_o      (dec_hit)
  );

  assign req_ready_o = (st_q == T_IDLE) && !suspend_i;
  assign accept      = req_valid_i && req_ready_o;
  assign more        = frm_done && (idx_q != last_q);
  assign idx_nx      = idx_q + 2'd1;
  assign frm_start   = (accept && dec_hit) || more;
  assign frm_addr    = (st_q == T_IDLE) ? req_addr_i : base_q + AW'(idx_nx);
  assign frm_wdata   = (st_q == T_IDLE) ? req_wdata_i[7:0] : wdata_q[8*int'(idx_nx) +: 8];
  assign frm_write   = (st_q == T_IDLE) ? req_write_i : write_q;

  always_comb begin
    acc_nx = acc_q;
    if (!write_q) acc_nx[8*int'(idx_q) +: 8] = frm_byte;
  end

  lpc_io_frame #(.AW(AW), .SYNC_TO(SYNC_TO), .ABORT_CLKS(ABORT_CLKS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .park_i     (suspend_i),
    .start_i    (frm_start),
    .write_i    (frm_write),
    .addr_i     (frm_addr),
    .wdata_i    (frm_wdata),
    .lad_i      (lad_i),
    .done_o     (frm_done),
    .idle_o     (frm_idle),
    .byte_o     (frm_byte),
    .err_o      (frm_err),
    .lframe_n_o (lframe_n_o),
    .lad_o      (lad_o),
    .lad_oe_o   (lad_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= T_IDLE;
      base_q      <= '0;
      last_q      <= '0;
      idx_q       <= '0;
      write_q     <= 1'b0;
      wdata_q     <= '0;
      acc_q       <= '0;
      err_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
      rsp_fwd_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        if (dec_hit) begin
          st_q    <= T_BUSY;
          base_q  <= req_addr_i;
          last_q  <= last_byte(req_size_i);
          idx_q   <= '0;
          write_q <= req_write_i;
          wdata_q <= req_wdata_i;
          acc_q   <= '0;
          err_q   <= 1'b0;
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_rdata_q <= '1;
          rsp_err_q   <= 1'b0;
          rsp_fwd_q   <= 1'b0;
        end
      end else if (st_q == T_BUSY && frm_done) begin
        acc_q <= acc_nx;
        err_q <= err_q | frm_err;
        if (idx_q == last_q) begin
          st_q        <= T_IDLE;
          rsp_valid_q <= 1'b1;
          rsp_rdata_q <= acc_nx;
          rsp_err_q   <= err_q | frm_err;
          rsp_fwd_q   <= 1'b1;
        end else begin
          idx_q <= idx_nx;
        end
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_fwd_o   = rsp_fwd_q;

endmodule

// File: rtl/lpc_io_seq_chk.sv
module lpc_io_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        suspend_i,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_rdata_o,
  input logic        rsp_err_o,
  input logic        rsp_fwd_o,
  input logic        lframe_n_o,
  input logic [3:0]  lad_o,
  input logic        lad_oe_o,
  input logic        dec_hit_i,
  input logic        frm_idle_i
);

  p_ready_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i |-> !req_ready_o);

  p_ready_bus_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (lframe_n_o && !lad_oe_o));

  p_miss_resp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fwd_o) |-> (rsp_rdata_o == 32'hFFFF_FFFF && !rsp_err_o));

  p_hit_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && dec_hit_i) |=> (!lframe_n_o && lad_oe_o && lad_o == 4'h0));

  p_start_then_dir_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lframe_n_o && lad_oe_o && lad_o == 4'h0)
      |=> (lframe_n_o && lad_oe_o && (lad_o == 4'h0 || lad_o == 4'h2)));

  p_err_only_fwd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> rsp_fwd_o);

  p_park_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_idle_i && suspend_i) |-> (!lframe_n_o && !lad_oe_o));

endmodule

bind lpc_io_seq lpc_io_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .suspend_i   (suspend_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_fwd_o   (rsp_fwd_o),
  .lframe_n_o  (lframe_n_o),
  .lad_o       (lad_o),
  .lad_oe_o    (lad_oe_o),
  .dec_hit_i   (dec_hit),
  .frm_idle_i  (frm_idle)
);

// File: tb/lpc_io_seq_bench.sv
module lpc_io_seq_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        suspend_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [15:0] req_addr_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_write_i = 1'b0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic        rsp_err_o, rsp_fwd_o;
  logic        cfg_we_i = 1'b0;
  logic [0:0]  cfg_idx_i = '0;
  logic [15:0] cfg_base_i = '0;
  logic [4:0]  cfg_log2_i = '0;
  logic        cfg_en_i = 1'b0;
  logic        lframe_n_o, lad_oe_o;
  logic [3:0]  lad_o;
  logic [3:0]  lad_i = 4'hF;

  always #4 clk = ~clk;

  lpc_io_seq u_lpc_io_seq (
    .clk_i(clk), .rst_ni(rst_ni), .suspend_i(suspend_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .req_size_i(req_size_i), .req_write_i(req_write_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
    .rsp_fwd_o(rsp_fwd_o), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_base_i(cfg_base_i), .cfg_log2_i(cfg_log2_i), .cfg_en_i(cfg_en_i),
    .lframe_n_o(lframe_n_o), .lad_o(lad_o), .lad_oe_o(lad_oe_o), .lad_i(lad_i)
  );

  typedef struct {
    logic       f;
    logic       oe;
    logic [3:0] lad;
    logic [3:0] drv;
  } cyc_t;

  int vec = 0;
  int bad = 0;

  // model state
  logic [15:0] m_base[2];
  int          m_lg[2];
  bit          m_en[2];
  int          s_wait[4];
  int          s_kind[4];   // 0 ready, 1 error, 2 silent
  logic [7:0]  s_rd[4];
  int          susp_at = -1;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got %0d expected 0", 1);
    summary();
  end

  function automatic cyc_t mk(logic f, logic oe, logic [3:0] lad, logic [3:0] drv);
    cyc_t c;
    c.f = f; c.oe = oe; c.lad = lad; c.drv = drv;
    return c;
  endfunction

  function automatic bit model_hit(logic [15:0] a);
    bit h = 0;
    for (int w = 0; w < 2; w++) begin
      logic [15:0] keep = (m_lg[w] >= 16) ? 16'h0 : (16'hFFFF << m_lg[w]);
      if (m_en[w] && ((a & keep) == (m_base[w] & keep))) h = 1;
    end
    return h;
  endfunction

  task automatic compare(string req, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_script(int k0, int k1, int k2, int k3, int w0);
    s_kind[0] = k0; s_kind[1] = k1; s_kind[2] = k2; s_kind[3] = k3;
    s_wait[0] = w0; s_wait[1] = 0; s_wait[2] = 0; s_wait[3] = 0;
  endtask

  task automatic cfg(int idx, logic [15:0] base, int lg, bit en);
    cfg_we_i = 1'b1; cfg_idx_i = 1'(idx); cfg_base_i = base;
    cfg_log2_i = 5'(lg); cfg_en_i = en;
    m_base[idx] = base; m_lg[idx] = lg; m_en[idx] = en;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // one host access; entered and left at a negedge
  task automatic access(string req, logic [15:0] addr, int sz, bit wr, logic [31:0] wd);
    cyc_t        q[$];
    int          nb;
    bit          hit;
    logic [31:0] exp_rd;
    bit          exp_err = 0;
    logic [7:0]  byt;
    nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    hit = model_hit(addr);
    exp_rd = hit ? 32'h0 : 32'hFFFF_FFFF;
    if (hit) begin
      for (int b = 0; b < nb; b++) begin
        logic [15:0] a = addr + 16'(b);
        q.push_back(mk(1'b0, 1'b1, 4'h0, 4'hF));
        q.push_back(mk(1'b1, 1'b1, wr ? 4'h2 : 4'h0, 4'hF));
        for (int n = 0; n < 4; n++) q.push_back(mk(1'b1, 1'b1, 4'(a >> (12 - 4 * n)), 4'hF));
        if (wr) begin
          q.push_back(mk(1'b1, 1'b1, wd[8*b +: 4], 4'hF));
          q.push_back(mk(1'b1, 1'b1, wd[8*b+4 +: 4], 4'hF));
        end
        q.push_back(mk(1'b1, 1'b1, 4'hF, 4'hF));
        q.push_back(mk(1'b1, 1'b0, 4'hF, 4'hF));
        for (int k = 0; k < s_wait[b]; k++) q.push_back(mk(1'b1, 1'b0, 4'hF, (k % 2) ? 4'h6 : 4'h5));
        if (s_kind[b] == 2) begin
          for (int k = 0; k < 4; k++) q.push_back(mk(1'b1, 1'b0, 4'hF, 4'hF));
          for (int k = 0; k < 4; k++) q.push_back(mk(1'b0, 1'b1, 4'hF, 4'hF));
          byt = 8'hFF;
        end else begin
          q.push_back(mk(1'b1, 1'b0, 4'hF, (s_kind[b] == 1) ? 4'hA : 4'h0));
          if (s_kind[b] == 1) exp_err = 1;
          if (!wr) begin
            q.push_back(mk(1'b1, 1'b0, 4'hF, s_rd[b][3:0]));
            q.push_back(mk(1'b1, 1'b0, 4'hF, s_rd[b][7:4]));
          end
          q.push_back(mk(1'b1, 1'b0, 4'hF, 4'hF));
          q.push_back(mk(1'b1, 1'b0, 4'hF, 4'hF));
          byt = s_rd[b];
        end
        if (!wr) exp_rd[8*b +: 8] = byt;
      end
    end
    req_valid_i = 1'b1; req_addr_i = addr; req_size_i = 2'(sz);
    req_write_i = wr; req_wdata_i = wd;
    compare("R1 ready before accept", 64'(req_ready_o), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      if (i == susp_at) suspend_i = 1'b1;
      lad_i = q[i].drv;
      compare({req, " bus trace"},
              {lframe_n_o, lad_oe_o, (q[i].oe ? lad_o : 4'h0), rsp_valid_o, req_ready_o},
              {q[i].f, q[i].oe, (q[i].oe ? q[i].lad : 4'h0), 1'b0, 1'b0});
      @(negedge clk);
    end
    lad_i = 4'hF;
    compare({req, " response"},
            {rsp_valid_o, rsp_fwd_o, rsp_err_o, lframe_n_o, lad_oe_o, req_ready_o, rsp_rdata_o},
            {1'b1, hit, exp_err, !suspend_i, 1'b0, !suspend_i, exp_rd});
  endtask

  initial begin
    s_rd[0] = 8'h5A; s_rd[1] = 8'h00; s_rd[2] = 8'h00; s_rd[3] = 8'h00;
    set_script(0, 0, 0, 0, 0);
    for (int w = 0; w < 2; w++) begin
      m_base[w] = '0; m_lg[w] = 0; m_en[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R10 reset state", {lframe_n_o, lad_oe_o, rsp_valid_o, req_ready_o}, {1'b1, 1'b0, 1'b0, 1'b1});

    access("R9 windows off after reset", 16'h0064, 0, 1'b0, 32'h0);
    cfg(0, 16'h0060, 4, 1'b1);
    cfg(1, 16'h0300, 3, 1'b1);

    access("R3 byte read", 16'h0064, 0, 1'b0, 32'h0);
    access("R3 byte write", 16'h0062, 0, 1'b1, 32'h0000_00C3);

    s_rd[0] = 8'h34; s_rd[1] = 8'h12;
    set_script(0, 0, 0, 0, 3);
    access("R5 waits, R7 halfword assembly", 16'h0302, 1, 1'b0, 32'h0);

    set_script(0, 0, 0, 0, 0);
    access("R4 word write split", 16'h0060, 2, 1'b1, 32'hDEAD_BEEF);
    access("R4 size code 3", 16'h0304, 3, 1'b1, 32'h0102_0304);

    s_rd[0] = 8'h11; s_rd[1] = 8'h22; s_rd[2] = 8'h33; s_rd[3] = 8'h44;
    set_script(0, 2, 1, 0, 1);
    access("R6 timeout lane, R5 error", 16'h0300, 2, 1'b0, 32'h0);

    set_script(2, 0, 0, 0, 0);
    access("R6 write timeout", 16'h0061, 0, 1'b1, 32'h0000_0077);

    set_script(0, 0, 0, 0, 0);
    access("R2 miss", 16'h0100, 1, 1'b0, 32'h0);
    s_rd[0] = 8'hA5;
    access("R9 window top edge", 16'h006F, 0, 1'b0, 32'h0);
    access("R2 just past window", 16'h0070, 0, 1'b0, 32'h0);

    cfg(1, 16'h0300, 3, 1'b0);
    access("R9 window disabled", 16'h0300, 0, 1'b0, 32'h0);

    // idle suspend: park, request ignored
    suspend_i = 1'b1;
    @(negedge clk);
    compare("R8 idle park", {lframe_n_o, lad_oe_o, req_ready_o}, {1'b0, 1'b0, 1'b0});
    req_valid_i = 1'b1; req_addr_i = 16'h0060; req_size_i = 2'd0; req_write_i = 1'b0;
    @(negedge clk);
    compare("R1 request ignored in suspend", {lframe_n_o, lad_oe_o, rsp_valid_o}, {1'b0, 1'b0, 1'b0});
    req_valid_i = 1'b0;
    @(negedge clk);
    compare("R1 still ignored", {lframe_n_o, lad_oe_o, rsp_valid_o}, {1'b0, 1'b0, 1'b0});
    suspend_i = 1'b0;
    @(negedge clk);
    compare("R10 resume idle", {lframe_n_o, lad_oe_o, req_ready_o}, {1'b1, 1'b0, 1'b1});

    // suspend raised mid-access: completes, then parks
    s_rd[0] = 8'h3C;
    susp_at = 5;
    access("R8 suspend during access", 16'h0065, 0, 1'b0, 32'h0);
    susp_at = -1;
    @(negedge clk);
    compare("R8 parked after completion", {lframe_n_o, lad_oe_o, req_ready_o}, {1'b0, 1'b0, 1'b0});
    suspend_i = 1'b0;
    @(negedge clk);

    summary();
  end

endmodule